// File: doc/BRIEF.md
# 32 kHz Oscillator Mode and Ready Controller

This block tracks the state of a low-frequency 32.768 kHz crystal oscillator. It decides whether the oscillator runs in noise-immune or low-current quiet operation, and it times the warm-up that must pass before the oscillator can be trusted. It also holds the CPU while it leaves stop mode.

A free-running tick input paces a warm-up counter. `WARM_TICKS` sets the warm-up length in ticks. The default of 8192 ticks at 32.768 kHz gives 250 ms, and a bench can pass a much smaller value.

The mode field uses this encoding:

- `00`: noise-immune operation.
- `01`: quiet operation.
- `10`: noise-immune, but quiet while in stop mode. On wake-up the CPU waits for the oscillator to be ready.
- `11`: noise-immune, but quiet while in stop mode. On wake-up the CPU resumes when the high-frequency clock reports it is usable, and the warm-up continues in parallel.

Top module: `oscReadyCtl`

## Requirements
- R1: While `rstN` is low and on the first cycle after it, `oscReady`, `quietMode` and `cpuHold` are 0. The oscillator counts as enabled, so a warm-up starts from zero.
- R2: A clock edge that samples `oscOff`=1 drives `oscReady` to 0 and `quietMode` to 0, and clears the warm-up count, so a later warm-up is a full one.
- R3: When the oscillator is enabled, in noise-immune operation and not ready, `oscReady` rises at the edge that samples the `WARM_TICKS`-th high `tick` counted from the start of the warm-up.
- R4: With `modeSel`=01 and the oscillator enabled, `quietMode` and `oscReady` are 1 after the next edge, with no warm-up.
- R5: A move from quiet to noise-immune operation while enabled drives `oscReady` to 0 at that edge and restarts the full warm-up of R3.
- R6: With `modeSel`=1x and the oscillator enabled, `quietMode` is 1 after an edge that samples `stopReq`=1, and it is 0 once `stopReq` is 0.
- R7: An edge that samples `stopReq`=1 sets `cpuHold` to 1.
- R8: With `modeSel`=10 and the oscillator enabled, once `stopReq` is 0 `cpuHold` stays 1 until an edge that samples `oscReady`=1 with `quietMode`=0, and it falls at that edge.
- R9: In every other case (`modeSel` 00, 01 or 11, or the oscillator disabled), once `stopReq` is 0 `cpuHold` falls at the first edge that samples `fllOk`=1, whatever the state of the warm-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low power-on reset |
| tick | input | 1 | Warm-up pacing strobe, one cycle per oscillator period |
| oscOff | input | 1 | 1 disables the oscillator amplifier |
| modeSel | input | 2 | Operating mode code (00, 01, 10, 11 as above) |
| stopReq | input | 1 | 1 while the CPU is in stop mode |
| fllOk | input | 1 | High-frequency clock is locked and usable |
| oscReady | output | 1 | Oscillator warmed up and usable |
| quietMode | output | 1 | 1 when the oscillator runs in quiet operation |
| cpuHold | output | 1 | 1 keeps the CPU stopped |

## Verification
The checks assume that every input is synchronous to `clk` and holds its value for a whole cycle. They also assume that `stopReq` is a level that stays high for the whole stop period, not a pulse. The bench changes inputs only on the falling edge and keeps `stopReq` high for several cycles per stop. The `tick` strobe runs at a fixed one-in-three rate, which gives warm-up lengths the bench can predict. Mode and disable changes are applied during warm-up, in quiet operation and in stop mode, so each hold and release path is driven within those limits.

// File: rtl/oscReadyPkg.sv
package oscReadyPkg;
  // Strobes from the mode controller to the warm-up datapath
  typedef struct packed {
    logic off;      // amplifier disabled: clear everything
    logic quiet;    // quiet operation next cycle: ready at once
    logic restart;  // leaving quiet operation: restart warm-up
    logic step;     // one warm-up tick
  } warmCtl_t;
endpackage

// File: rtl/oscWarmDp.sv
module oscWarmDp
  import oscReadyPkg::*;
#(
  parameter int WARM_TICKS = 8192
) (
  input  logic     clk,
  input  logic     rstN,
  input  warmCtl_t ctl,
  output logic     readyQ
);
  localparam int CW = (WARM_TICKS < 2) ? 1 : $clog2(WARM_TICKS);
  localparam logic [CW-1:0] LAST = CW'(WARM_TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      readyQ <= 1'b0;
    end else if (ctl.off) begin
      cnt    <= '0;
      readyQ <= 1'b0;
    end else if (ctl.quiet) begin
      cnt    <= '0;
      readyQ <= 1'b1;
    end else if (ctl.restart) begin
      cnt    <= '0;
      readyQ <= 1'b0;
    end else if (ctl.step && !readyQ) begin
      if (cnt == LAST) begin
        cnt    <= '0;
        readyQ <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/oscModeCtrl.sv
module oscModeCtrl
  import oscReadyPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       oscOff,
  input  logic [1:0] modeSel,
  input  logic       stopReq,
  input  logic       fllOk,
  input  logic       readyQ,
  output warmCtl_t   ctl,
  output logic       quietQ,
  output logic       holdQ
);
  logic enabled;
  logic quietNext;
  logic waitReady;
  logic release_;

  always_comb begin
    enabled   = !oscOff;
    quietNext = enabled && ((modeSel == 2'b01) || (modeSel[1] && stopReq));
    waitReady = enabled && (modeSel == 2'b10);
    release_  = waitReady ? (readyQ && !quietQ) : fllOk;
    ctl.off     = oscOff;
    ctl.quiet   = quietNext;
    ctl.restart = quietQ && !quietNext;
    ctl.step    = tick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quietQ <= 1'b0;
      holdQ  <= 1'b0;
    end else begin
      quietQ <= quietNext;
      holdQ  <= stopReq || (holdQ && !release_);
    end
  end
endmodule

// File: rtl/oscReadyCtl.sv
module oscReadyCtl
  import oscReadyPkg::*;
#(
  parameter int WARM_TICKS = 8192
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       oscOff,
  input  logic [1:0] modeSel,
  input  logic       stopReq,
  input  logic       fllOk,
  output logic       oscReady,
  output logic       quietMode,
  output logic       cpuHold
);
  warmCtl_t ctl;
  logic     readyQ;
  logic     quietQ;
  logic     holdQ;

  oscModeCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .oscOff  (oscOff),
    .modeSel (modeSel),
    .stopReq (stopReq),
    .fllOk   (fllOk),
    .readyQ  (readyQ),
    .ctl     (ctl),
    .quietQ  (quietQ),
    .holdQ   (holdQ)
  );

  oscWarmDp #(.WARM_TICKS(WARM_TICKS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .readyQ (readyQ)
  );

  assign oscReady  = readyQ;
  assign quietMode = quietQ;
  assign cpuHold   = holdQ;
endmodule

// File: rtl/oscReadyCtl_chk.sv
module oscReadyCtl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       tick,
  input logic       oscOff,
  input logic [1:0] modeSel,
  input logic       stopReq,
  input logic       fllOk,
  input logic       oscReady,
  input logic       quietMode,
  input logic       cpuHold
);
  a_r2_off_clears: assert property (@(posedge clk) disable iff (!rstN)
    oscOff |=> (!oscReady && !quietMode));

  a_r3_rise_needs_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oscReady) |-> ($past(tick) || quietMode));

  a_r4_quiet_is_ready: assert property (@(posedge clk) disable iff (!rstN)
    quietMode |-> oscReady);

  a_r5_leave_quiet_clears: assert property (@(posedge clk) disable iff (!rstN)
    $fell(quietMode) |-> !oscReady);

  a_r6_stop_goes_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq && modeSel[1] && !oscOff) |=> quietMode);

  a_r7_stop_holds: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> cpuHold);

  a_r8_wait_ready: assert property (@(posedge clk) disable iff (!rstN)
    (cpuHold && !stopReq && modeSel == 2'b10 && !oscOff && !(oscReady && !quietMode))
      |=> cpuHold);

  a_r9_wait_fll: assert property (@(posedge clk) disable iff (!rstN)
    (cpuHold && !stopReq && !(modeSel == 2'b10 && !oscOff) && !fllOk) |=> cpuHold);
endmodule

bind oscReadyCtl oscReadyCtl_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tick      (tick),
  .oscOff    (oscOff),
  .modeSel   (modeSel),
  .stopReq   (stopReq),
  .fllOk     (fllOk),
  .oscReady  (oscReady),
  .quietMode (quietMode),
  .cpuHold   (cpuHold)
);

// File: tb/oscReadyCtl_tb.sv
`timescale 1ns/1ps
module oscReadyCtl_tb;
  localparam int W = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       oscOff = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic       stopReq = 1'b0;
  logic       fllOk = 1'b0;
  logic       oscReady, quietMode, cpuHold;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string tag = "R1";

  // behavioural reference state
  int mCnt = 0;
  bit mRdy = 0, mQuiet = 0, mHold = 0;

  always #2 clk = ~clk;

  oscReadyCtl #(.WARM_TICKS(W)) u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .oscOff(oscOff), .modeSel(modeSel),
    .stopReq(stopReq), .fllOk(fllOk),
    .oscReady(oscReady), .quietMode(quietMode), .cpuHold(cpuHold)
  );

  // reference model: applies the requirements to the inputs seen at each edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mRdy = 0; mQuiet = 0; mHold = 0;
    end else begin
      bit en, wantQuiet, canGo;
      en = !oscOff;
      wantQuiet = en && (modeSel == 2'b01 || (modeSel[1] && stopReq));
      if (modeSel == 2'b10 && en) canGo = mRdy && !mQuiet;   // R8
      else canGo = fllOk;                                      // R9
      if (stopReq) mHold = 1;                                  // R7
      else if (mHold && canGo) mHold = 0;
      if (!en) begin mCnt = 0; mRdy = 0; end                   // R2
      else if (wantQuiet) begin mCnt = 0; mRdy = 1; end        // R4, R6
      else if (mQuiet) begin mCnt = 0; mRdy = 0; end           // R5
      else if (!mRdy && tick) begin                            // R3
        mCnt++;
        if (mCnt == W) begin mRdy = 1; mCnt = 0; end
      end
      mQuiet = wantQuiet;
    end
  end

  // tick strobe, one cycle in three
  always @(negedge clk) begin
    cyc++;
    tick <= (cyc % 3 == 0);
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    checks++;
    if (oscReady !== mRdy || quietMode !== mQuiet || cpuHold !== mHold) begin
      fails++;
      $display("FAIL %s cycle %0d: ready/quiet/hold actual %b%b%b expected %b%b%b",
               tag, cyc, oscReady, quietMode, cpuHold, mRdy, mQuiet, mHold);
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect1(input string t, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", t, act, exp);
    end
  endtask

  initial begin
    tag = "R1"; run(3);
    expect1("R1 ready after reset", oscReady, 1'b0);
    rstN = 1'b1;
    run(1);
    expect1("R1 hold after reset", cpuHold, 1'b0);
    tag = "R3"; run(20);
    expect1("R3 warmed up", oscReady, 1'b1);
    tag = "R4"; modeSel = 2'b01; run(1);
    expect1("R4 quiet ready", oscReady, 1'b1);
    run(4);
    tag = "R5"; modeSel = 2'b00; run(1);
    expect1("R5 ready cleared", oscReady, 1'b0);
    run(20);
    tag = "R2"; run(3); oscOff = 1'b1; run(1);
    expect1("R2 off clears ready", oscReady, 1'b0);
    modeSel = 2'b01; run(4);
    expect1("R2 off blocks quiet", quietMode, 1'b0);
    oscOff = 1'b0; modeSel = 2'b00; run(7);
    expect1("R2 warm-up full after off", oscReady, 1'b0);
    run(14);
    tag = "R6"; modeSel = 2'b10; stopReq = 1'b1; run(1);
    expect1("R6 quiet in stop", quietMode, 1'b1);
    expect1("R7 hold in stop", cpuHold, 1'b1);
    fllOk = 1'b1; run(8);
    tag = "R8"; stopReq = 1'b0; run(3);
    expect1("R8 still held during warm-up", cpuHold, 1'b1);
    run(25);
    expect1("R8 released after warm-up", cpuHold, 1'b0);
    tag = "R9"; modeSel = 2'b11; fllOk = 1'b0; stopReq = 1'b1; run(6);
    stopReq = 1'b0; run(4);
    expect1("R9 held without fll", cpuHold, 1'b1);
    fllOk = 1'b1; run(1);
    expect1("R9 released on fll", cpuHold, 1'b0);
    expect1("R9 warm-up still running", oscReady, 1'b0);
    run(20);
    fllOk = 1'b0; modeSel = 2'b00; stopReq = 1'b1; run(3);
    expect1("R6 mode 00 stays noisy", quietMode, 1'b0);
    stopReq = 1'b0; run(3); fllOk = 1'b1; run(3);
    tag = "R9"; oscOff = 1'b1; modeSel = 2'b10; fllOk = 1'b0; stopReq = 1'b1; run(3);
    stopReq = 1'b0; run(2); fllOk = 1'b1; run(2);
    expect1("R9 disabled uses fll", cpuHold, 1'b0);
    oscOff = 1'b0; run(25);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule